// File: doc/BRIEF.md
# Vector Element Writeback Sequencer

This block runs one register-to-register vector operation at a time over a file of sixteen vector registers, each holding sixty-four 64-bit elements. After a start pulse it walks the element indices upward, one element per clock, from index 0. For each index it reads the two source elements, computes the result and writes it into the destination register. The walk stops at the vector length. A 64-bit mask can also qualify each element, so that unselected elements are skipped.

The supported operations are bitwise AND, OR and XOR on the low 32 bits, and 32-bit add, left shift and logical right shift. The upper half of each destination element follows a rule that depends on the operation. Logical operations copy the upper half of the second source into it. Arithmetic and shift operations write zeros there. The length register and the mask register are loaded through their own write ports and captured at start. A side port loads and reads single elements while the block is idle.

Top module: `vwb_engine`

## Requirements
- R1: While reset is applied and after it is released, `busy` and `done` are both 0 until a start is accepted.
- R2: The operation code selects the operation: 0 is AND, 1 is OR, 2 is XOR, 3 is add, 4 is shift left and 5 is logical shift right. For codes 0, 1 and 2, bits 31:0 of a written element are the bitwise operation of bits 31:0 of the two sources, and bits 63:32 are bits 63:32 of source B.
- R3: For code 3, bits 31:0 of the result are the sum of the low halves of source A and source B, modulo 2^32, and bits 63:32 are zero.
- R4: For code 4, bits 31:0 of the result are the low half of source A shifted left by bits 4:0 of source B. For code 5 they are the same low half shifted right logically by that amount. In both cases bits 63:32 are zero.
- R5: Destination elements with an index at or above the effective length keep their previous contents.
- R6: A length of 0 writes no element, and `done` rises in the cycle after the start edge.
- R7: A length register value above 64 acts as a length of 64.
- R8: With `mask_en` high at start, an element i below the length is written only if mask bit i is 1, where bit 0 maps to element 0. If the bit is 0, the element keeps its contents.
- R9: With `mask_en` low at start, every element below the length is written, whatever the mask holds.
- R10: For an effective length L above 0, `busy` is high for L cycles after the start edge, with one element index handled per cycle. `done` is a single-cycle pulse in the cycle after the last element cycle, and it is never high together with `busy`.
- R11: A start pulse while `busy` is high is ignored. It neither changes the running operation nor touches the register it names.
- R12: The destination may be the same register as either source. Each element is computed from the source values as they stood before that element was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Side-port element write, used only while idle |
| ld_reg | input | 4 | Side-port register number |
| ld_idx | input | 6 | Side-port element index |
| ld_data | input | 64 | Side-port element write data |
| rd_reg | input | 4 | Read-back register number |
| rd_idx | input | 6 | Read-back element index |
| rd_data | output | 64 | Read-back element value (combinational) |
| len_we | input | 1 | Length register write enable |
| len_wdata | input | 7 | Length register write value |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 64 | Mask register write value |
| start | input | 1 | Start pulse that captures the operation fields |
| op | input | 3 | Operation code |
| dst | input | 4 | Destination register number |
| srca | input | 4 | Source A register number |
| srcb | input | 4 | Source B register number |
| mask_en | input | 1 | Mask qualification enable |
| busy | output | 1 | An operation is stepping through elements |
| done | output | 1 | Single-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a second start arriving in the middle of a run. In that case both the running operation and the register named by the ignored request have to come out untouched. The bench reaches it by timing a second start a few cycles into a ten-element run. It names a different operation and a different destination, and then checks both the cycle count and both registers. The in-place case is also hard to reach. There, the destination is also a source, and a stale read would go unnoticed unless the expected values come from a snapshot taken before the run. The bench loads a pattern, takes that snapshot, and compares all 64 elements after the run.

// File: rtl/vwb_pkg.sv
package vwb_pkg;
  localparam int NREG   = 16;
  localparam int NELEM  = 64;
  localparam int DW     = 64;
  localparam int HW     = DW / 2;
  localparam int REG_W  = $clog2(NREG);
  localparam int IDX_W  = $clog2(NELEM);
  localparam int LEN_W  = IDX_W + 1;
  localparam int SHW    = $clog2(HW);

  typedef enum logic [2:0] {
    OP_AND = 3'd0,
    OP_OR  = 3'd1,
    OP_XOR = 3'd2,
    OP_ADD = 3'd3,
    OP_SLL = 3'd4,
    OP_SRL = 3'd5
  } vop_e;
endpackage

// File: rtl/vwb_regfile.sv
module vwb_regfile
  import vwb_pkg::*;
#(
  parameter int P_NREG  = NREG,
  parameter int P_NELEM = NELEM,
  parameter int P_DW    = DW
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [$clog2(P_NREG)-1:0]   wreg,
  input  logic [$clog2(P_NELEM)-1:0]  widx,
  input  logic [P_DW-1:0]             wdata,
  input  logic [$clog2(P_NREG)-1:0]   areg,
  input  logic [$clog2(P_NREG)-1:0]   breg,
  input  logic [$clog2(P_NREG)-1:0]   xreg,
  input  logic [$clog2(P_NELEM)-1:0]  ridx,
  input  logic [$clog2(P_NELEM)-1:0]  xidx,
  output logic [P_DW-1:0]             adata,
  output logic [P_DW-1:0]             bdata,
  output logic [P_DW-1:0]             xdata
);
  localparam int RW    = $clog2(P_NREG);
  localparam int IW    = $clog2(P_NELEM);
  localparam int DEPTH = P_NREG * P_NELEM;

  logic [P_DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[{wreg, widx}] <= wdata;
    end
  end

  assign adata = mem[{areg, ridx}];
  assign bdata = mem[{breg, ridx}];
  assign xdata = mem[{xreg, xidx}];

  logic [RW+IW-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/vwb_lane.sv
module vwb_lane
  import vwb_pkg::*;
#(
  parameter int P_DW = DW
) (
  input  vop_e              op,
  input  logic [P_DW-1:0]   a,
  input  logic [P_DW-1:0]   b,
  output logic [P_DW-1:0]   y
);
  localparam int LH  = P_DW / 2;
  localparam int SHB = $clog2(LH);

  logic [LH-1:0]  alo, blo, res_lo;
  logic [SHB-1:0] sh;
  logic           keep_hi;

  assign alo = a[LH-1:0];
  assign blo = b[LH-1:0];
  assign sh  = blo[SHB-1:0];

  always_comb begin
    res_lo  = '0;
    keep_hi = 1'b0;
    unique case (op)
      OP_AND: begin res_lo = alo & blo; keep_hi = 1'b1; end
      OP_OR:  begin res_lo = alo | blo; keep_hi = 1'b1; end
      OP_XOR: begin res_lo = alo ^ blo; keep_hi = 1'b1; end
      OP_ADD: res_lo = alo + blo;
      OP_SLL: res_lo = alo << sh;
      OP_SRL: res_lo = alo >> sh;
      default: res_lo = '0;
    endcase
  end

  assign y = {(keep_hi ? b[P_DW-1:LH] : {LH{1'b0}}), res_lo};

  logic unused_a;
  assign unused_a = ^a[P_DW-1:LH];
endmodule

// File: rtl/vwb_ctrl.sv
module vwb_ctrl
  import vwb_pkg::*;
#(
  parameter int P_NELEM = NELEM,
  parameter int P_NREG  = NREG
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  vop_e                          op,
  input  logic [$clog2(P_NREG)-1:0]     dst,
  input  logic [$clog2(P_NREG)-1:0]     srca,
  input  logic [$clog2(P_NREG)-1:0]     srcb,
  input  logic                          mask_en,
  input  logic [$clog2(P_NELEM):0]      len_raw,
  input  logic [P_NELEM-1:0]            mask,
  output logic                          busy,
  output logic                          done,
  output logic                          wr_en,
  output logic [$clog2(P_NELEM)-1:0]    idx,
  output logic [$clog2(P_NELEM):0]      run_len,
  output logic                          run_men,
  output logic [P_NELEM-1:0]            run_mask,
  output vop_e                          run_op,
  output logic [$clog2(P_NREG)-1:0]     run_dst,
  output logic [$clog2(P_NREG)-1:0]     run_a,
  output logic [$clog2(P_NREG)-1:0]     run_b
);
  localparam int IW = $clog2(P_NELEM);
  localparam int LW = IW + 1;
  localparam logic [LW-1:0] MAXLEN = LW'(P_NELEM);

  logic            busy_q, busy_d, done_q, done_d;
  logic [LW-1:0]   cnt_q, cnt_d, len_q, len_d, eff_len;
  logic            men_q, men_d;
  logic [P_NELEM-1:0] mask_q, mask_d;
  vop_e            op_q, op_d;
  logic [$clog2(P_NREG)-1:0] dst_q, dst_d, a_q, a_d, b_q, b_d;
  logic            accept, last, run_ce;

  assign eff_len = (len_raw > MAXLEN) ? MAXLEN : len_raw;
  assign accept  = start && !busy_q;
  assign last    = busy_q && (cnt_q == len_q - LW'(1));
  assign run_ce  = accept;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    len_d  = len_q;
    men_d  = men_q;
    mask_d = mask_q;
    op_d   = op_q;
    dst_d  = dst_q;
    a_d    = a_q;
    b_d    = b_q;
    if (accept) begin
      len_d  = eff_len;
      cnt_d  = '0;
      busy_d = (eff_len != '0);
      done_d = (eff_len == '0);
      men_d  = mask_en;
      mask_d = mask;
      op_d   = op;
      dst_d  = dst;
      a_d    = srca;
      b_d    = srcb;
    end else if (busy_q) begin
      cnt_d = cnt_q + LW'(1);
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (accept || busy_q) begin
        cnt_q <= cnt_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      men_q  <= 1'b0;
      mask_q <= '0;
      op_q   <= OP_AND;
      dst_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
    end else if (run_ce) begin
      len_q  <= len_d;
      men_q  <= men_d;
      mask_q <= mask_d;
      op_q   <= op_d;
      dst_q  <= dst_d;
      a_q    <= a_d;
      b_q    <= b_d;
    end
  end

  assign idx      = cnt_q[IW-1:0];
  assign wr_en    = busy_q && (!men_q || mask_q[cnt_q[IW-1:0]]);
  assign busy     = busy_q;
  assign done     = done_q;
  assign run_len  = len_q;
  assign run_men  = men_q;
  assign run_mask = mask_q;
  assign run_op   = op_q;
  assign run_dst  = dst_q;
  assign run_a    = a_q;
  assign run_b    = b_q;
endmodule

// File: rtl/vwb_engine.sv
module vwb_engine
  import vwb_pkg::*;
#(
  parameter int P_NREG  = NREG,
  parameter int P_NELEM = NELEM,
  parameter int P_DW    = DW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_we,
  input  logic [$clog2(P_NREG)-1:0]     ld_reg,
  input  logic [$clog2(P_NELEM)-1:0]    ld_idx,
  input  logic [P_DW-1:0]               ld_data,
  input  logic [$clog2(P_NREG)-1:0]     rd_reg,
  input  logic [$clog2(P_NELEM)-1:0]    rd_idx,
  output logic [P_DW-1:0]               rd_data,
  input  logic                          len_we,
  input  logic [$clog2(P_NELEM):0]      len_wdata,
  input  logic                          mask_we,
  input  logic [P_NELEM-1:0]            mask_wdata,
  input  logic                          start,
  input  logic [2:0]                    op,
  input  logic [$clog2(P_NREG)-1:0]     dst,
  input  logic [$clog2(P_NREG)-1:0]     srca,
  input  logic [$clog2(P_NREG)-1:0]     srcb,
  input  logic                          mask_en,
  output logic                          busy,
  output logic                          done
);
  localparam int RW = $clog2(P_NREG);
  localparam int IW = $clog2(P_NELEM);
  localparam int LW = IW + 1;

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [LW-1:0]      len_q;
  logic [P_NELEM-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      mask_q <= '0;
    end else begin
      if (len_we)  len_q  <= len_wdata;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  logic               wr_en;
  logic [IW-1:0]      idx;
  logic [LW-1:0]      run_len;
  logic               run_men;
  logic [P_NELEM-1:0] run_mask;
  vop_e               run_op;
  logic [RW-1:0]      run_dst, run_a, run_b;

  vwb_ctrl #(.P_NELEM(P_NELEM), .P_NREG(P_NREG)) u_ctrl (
    .clk(clk), .rst_n(rst_ni), .start(start), .op(vop_e'(op)),
    .dst(dst), .srca(srca), .srcb(srcb), .mask_en(mask_en),
    .len_raw(len_q), .mask(mask_q), .busy(busy), .done(done),
    .wr_en(wr_en), .idx(idx), .run_len(run_len), .run_men(run_men),
    .run_mask(run_mask), .run_op(run_op), .run_dst(run_dst),
    .run_a(run_a), .run_b(run_b)
  );

  logic [P_DW-1:0] a_el, b_el, y_el, rf_wdata;
  logic            rf_we;
  logic [RW-1:0]   rf_wreg;
  logic [IW-1:0]   rf_widx;

  vwb_lane #(.P_DW(P_DW)) u_lane (
    .op(run_op), .a(a_el), .b(b_el), .y(y_el)
  );

  always_comb begin
    if (busy) begin
      rf_we    = wr_en;
      rf_wreg  = run_dst;
      rf_widx  = idx;
      rf_wdata = y_el;
    end else begin
      rf_we    = ld_we;
      rf_wreg  = ld_reg;
      rf_widx  = ld_idx;
      rf_wdata = ld_data;
    end
  end

  vwb_regfile #(.P_NREG(P_NREG), .P_NELEM(P_NELEM), .P_DW(P_DW)) u_rf (
    .clk(clk), .we(rf_we), .wreg(rf_wreg), .widx(rf_widx), .wdata(rf_wdata),
    .areg(run_a), .breg(run_b), .xreg(rd_reg), .ridx(idx), .xidx(rd_idx),
    .adata(a_el), .bdata(b_el), .xdata(rd_data)
  );
endmodule

// File: rtl/vwb_engine_chk.sv
module vwb_engine_chk #(
  parameter int P_NELEM = 64
) (
  input logic                        clk,
  input logic                        rst_ni,
  input logic                        start,
  input logic                        busy,
  input logic                        done,
  input logic                        wr_en,
  input logic [$clog2(P_NELEM)-1:0]  idx,
  input logic [$clog2(P_NELEM):0]    run_len,
  input logic                        run_men,
  input logic [P_NELEM-1:0]          run_mask,
  input logic [$clog2(P_NELEM):0]    len_q
);
  localparam int LW = $clog2(P_NELEM) + 1;
  localparam logic [LW-1:0] MAXL = LW'(P_NELEM);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done); // R10
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_ni)
    !(busy && done)); // R10
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    busy && $past(busy) |-> idx == $past(idx) + 1'b1); // R10
  AST_WR_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |-> ({1'b0, idx} < run_len)); // R5
  AST_WR_MASK_BIT: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en && run_men |-> run_mask[idx]); // R8
  AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (!rst_ni)
    start && !busy && len_q == '0 |=> done && !busy); // R6
  AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_ni)
    start && !busy && len_q > MAXL |=> run_len == MAXL); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_ni)
    busy && start |=> $stable(run_len) && $stable(run_mask)); // R11
endmodule

bind vwb_engine vwb_engine_chk #(.P_NELEM(P_NELEM)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .start(start), .busy(busy), .done(done),
  .wr_en(wr_en), .idx(idx), .run_len(run_len), .run_men(run_men),
  .run_mask(run_mask), .len_q(len_q)
);

// File: tb/vwb_engine_test.sv
module vwb_engine_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  d;
    logic [3:0]  a;
    logic [3:0]  b;
    logic [6:0]  len;
    logic        men;
    logic [63:0] mask;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 4'd1,  4'd2,  4'd3,  7'd64,  1'b0, 64'h0},
    '{3'd1, 4'd4,  4'd5,  4'd6,  7'd10,  1'b0, 64'h0},
    '{3'd2, 4'd7,  4'd8,  4'd9,  7'd33,  1'b1, 64'hF0F0_1234_5678_9ABC},
    '{3'd3, 4'd1,  4'd2,  4'd3,  7'd64,  1'b0, 64'h0},
    '{3'd4, 4'd10, 4'd11, 4'd12, 7'd5,   1'b0, 64'h0},
    '{3'd5, 4'd13, 4'd14, 4'd15, 7'd100, 1'b0, 64'h0},
    '{3'd3, 4'd0,  4'd0,  4'd1,  7'd20,  1'b1, 64'h5555_5555_5555_5555},
    '{3'd2, 4'd2,  4'd3,  4'd2,  7'd1,   1'b1, 64'h1},
    '{3'd0, 4'd5,  4'd6,  4'd7,  7'd64,  1'b1, 64'h8000_0000_0000_0001},
    '{3'd1, 4'd8,  4'd9,  4'd10, 7'd0,   1'b0, 64'hFFFF},
    '{3'd3, 4'd11, 4'd12, 4'd13, 7'd63,  1'b0, 64'h0},
    '{3'd5, 4'd14, 4'd15, 4'd0,  7'd7,   1'b0, 64'h0000_0000_0000_0000}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic ld_we; logic [3:0] ld_reg; logic [5:0] ld_idx; logic [63:0] ld_data;
  logic [3:0] rd_reg; logic [5:0] rd_idx; logic [63:0] rd_data;
  logic len_we; logic [6:0] len_wdata;
  logic mask_we; logic [63:0] mask_wdata;
  logic start; logic [2:0] op; logic [3:0] dst, srca, srcb; logic mask_en;
  logic busy, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vwb_engine uut (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_reg(ld_reg), .ld_idx(ld_idx),
    .ld_data(ld_data), .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data),
    .len_we(len_we), .len_wdata(len_wdata), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .start(start), .op(op), .dst(dst), .srca(srca),
    .srcb(srcb), .mask_en(mask_en), .busy(busy), .done(done)
  );

  function automatic logic [63:0] pat(int r, int i, int v);
    logic [31:0] hi, lo;
    hi = 32'(r) * 32'h0101_0007 + 32'(v) * 32'h0000_1111 + 32'(i) * 32'h1357_0003;
    lo = (32'(i) * 32'h9E37_79B9) ^ (32'(r) * 32'h0123_4567) ^ (32'(v) * 32'h00FF_00FF);
    return {hi, lo};
  endfunction

  function automatic logic [63:0] model(logic [2:0] o, logic [63:0] a, logic [63:0] b);
    logic [31:0] al, bl;
    al = a[31:0]; bl = b[31:0];
    case (o)
      3'd0: return {b[63:32], al & bl};
      3'd1: return {b[63:32], al | bl};
      3'd2: return {b[63:32], al ^ bl};
      3'd3: return {32'h0, al + bl};
      3'd4: return {32'h0, al << bl[4:0]};
      3'd5: return {32'h0, al >> bl[4:0]};
      default: return 64'h0;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic put(int r, int i, logic [63:0] d);
    ld_we = 1'b1; ld_reg = 4'(r); ld_idx = 6'(i); ld_data = d;
    tick();
    ld_we = 1'b0;
  endtask

  task automatic get(int r, int i, output logic [63:0] d);
    rd_reg = 4'(r); rd_idx = 6'(i); #1; d = rd_data;
  endtask

  task automatic set_regs(logic [6:0] l, logic [63:0] m);
    len_we = 1'b1; len_wdata = l; mask_we = 1'b1; mask_wdata = m;
    tick();
    len_we = 1'b0; mask_we = 1'b0;
  endtask

  // Issues a start and counts cycles from the start edge to the done pulse.
  task automatic launch(vec_t t, output int cyc);
    op = t.op; dst = t.d; srca = t.a; srcb = t.b; mask_en = t.men;
    start = 1'b1;
    tick();
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin tick(); cyc++; end
  endtask

  logic [63:0] snap_a [64];
  logic [63:0] snap_b [64];
  logic [63:0] snap_d [64];

  task automatic prepare(vec_t t, int v);
    for (int i = 0; i < 64; i++) begin
      put(t.d, i, pat(t.d, i, v));
      put(t.a, i, pat(t.a, i, v));
      put(t.b, i, pat(t.b, i, v));
    end
    for (int i = 0; i < 64; i++) begin
      get(t.a, i, snap_a[i]); get(t.b, i, snap_b[i]); get(t.d, i, snap_d[i]);
    end
  endtask

  task automatic verify_dst(vec_t t, string req);
    int eff; int bad; logic [63:0] got, exp, bg, be;
    eff = (t.len > 7'd64) ? 64 : int'(t.len);
    bad = 0; bg = '0; be = '0;
    for (int i = 0; i < 64; i++) begin
      get(t.d, i, got);
      if (i < eff && (!t.men || t.mask[i])) exp = model(t.op, snap_a[i], snap_b[i]);
      else exp = snap_d[i];
      if (got !== exp && bad == 0) begin bg = got; be = exp; bad = 1; end
    end
    check(bad == 0, req, bg, be);
  endtask

  initial begin
    int cyc;
    logic [63:0] g;
    rst_n = 1'b0; ld_we = 0; ld_reg = 0; ld_idx = 0; ld_data = 0;
    rd_reg = 0; rd_idx = 0; len_we = 0; len_wdata = 0; mask_we = 0;
    mask_wdata = 0; start = 0; op = 0; dst = 0; srca = 0; srcb = 0; mask_en = 0;
    repeat (3) tick();
    check(busy == 1'b0 && done == 1'b0, "R1 in reset", {62'h0, busy, done}, 64'h0);
    rst_n = 1'b1;
    repeat (4) tick();
    check(busy == 1'b0 && done == 1'b0, "R1 after reset", {62'h0, busy, done}, 64'h0);

    // Table walk: R2 R3 R4 R5 R7 R8 R9 R12 and R10 timing
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int eff;
      t = VECS[v];
      eff = (t.len > 7'd64) ? 64 : int'(t.len);
      prepare(t, v);
      set_regs(t.len, t.mask);
      launch(t, cyc);
      check(cyc == eff, "R10/R6/R7 cycles to done", 64'(cyc), 64'(eff));
      tick();
      check(done == 1'b0 && busy == 1'b0, "R10 done single pulse", {62'h0, busy, done}, 64'h0);
      verify_dst(t, "R2/R3/R4/R5/R8/R9/R12 dst contents");
    end

    // Directed R11: second start mid-run is dropped
    begin
      vec_t t1, t2;
      logic [63:0] other [64];
      int bad;
      t1 = '{3'd3, 4'd6, 4'd7, 4'd8, 7'd10, 1'b0, 64'h0};
      t2 = '{3'd1, 4'd9, 4'd7, 4'd8, 7'd10, 1'b0, 64'h0};
      for (int i = 0; i < 64; i++) begin put(9, i, pat(9, i, 77)); other[i] = pat(9, i, 77); end
      prepare(t1, 40);
      set_regs(t1.len, t1.mask);
      op = t1.op; dst = t1.d; srca = t1.a; srcb = t1.b; mask_en = 1'b0;
      start = 1'b1; tick(); start = 1'b0;
      cyc = 0;
      repeat (3) begin tick(); cyc++; end
      op = t2.op; dst = t2.d; start = 1'b1; tick(); cyc++; start = 1'b0;
      while (!done && cyc < 200) begin tick(); cyc++; end
      check(cyc == 10, "R11 run length unchanged", 64'(cyc), 64'd10);
      tick();
      check(busy == 1'b0, "R11 no second run", {63'h0, busy}, 64'h0);
      verify_dst(t1, "R11 first op result");
      bad = 0;
      for (int i = 0; i < 64; i++) begin get(9, i, g); if (g !== other[i]) bad++; end
      check(bad == 0, "R11 ignored dst untouched", 64'(bad), 64'h0);
    end

    // Directed R6: zero length with masking leaves every element
    begin
      vec_t t;
      t = '{3'd3, 4'd4, 4'd5, 4'd6, 7'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF};
      prepare(t, 90);
      set_regs(t.len, t.mask);
      launch(t, cyc);
      check(cyc == 0, "R6 done right after start", 64'(cyc), 64'h0);
      verify_dst(t, "R6 no element written");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule